// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Mode Register File

This block sits on the device side of a double-data-rate SDRAM command bus. On every rising clock edge it samples the active-low command strobes (chip select, row strobe, column strobe, write enable), the clock-enable input, two bank bits and twelve address bits. It turns each sampled command into a registered one-hot code, with the bank, row, column and auto-precharge request that go with it. It keeps the clock-enable value of the previous cycle, so that a refresh taken while clock enable falls becomes self-refresh entry and any other command taken while it falls becomes power-down entry. The following rise is reported as the matching exit.

The block also holds the mode register and the extended mode register. The bank bits of a register-set command choose which one is written. From their contents it drives the burst length, burst ordering, read latency, test mode, DLL reset, DLL enable and output drive strength to the rest of the device. A reserved code is rejected: a one-cycle error pulse is raised and the register keeps its previous contents. Each register reports a valid flag once it has accepted its first write.

Top module: `sdram_cmd_decode`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd` is zero. Both valid flags, `burst_len`, `cas_lat`, `dll_en`, `drive_str` and `cfg_err` are zero until the registers are written.
- R2: With clock enable high in both the previous and the current cycle, and chip select low, the strobes {ras_n,cas_n,we_n} decode one cycle after the sampling edge into these `cmd` bits: 111 no-op (bit 1), 011 activate (bit 2), 010 precharge (bit 3, or bit 4 when addr[8]=1), 101 read (bit 5), 100 write (bit 6), 110 burst stop (bit 7), 001 auto refresh (bit 8), 000 register set (bit 11 for bank 00, bit 12 for bank 01). At most one `cmd` bit is ever high.
- R3: With clock enable high in both cycles and chip select high, `cmd` is bit 0 (deselect), whatever the other strobes are.
- R4: The bank, row (addr) and column (addr[7:0]) of every command appear on `cmd_bank`, `cmd_row` and `cmd_col` with `cmd`. `cmd_ap` equals addr[8] for read and write and is 0 for all other commands.
- R5: A register-set command to bank 00 loads the mode register. The fields are: addr[2:0] burst length (001 gives 2, 010 gives 4, 011 gives 8, 111 gives 256), addr[3] burst ordering (1 interleaved), addr[6:4] read latency (011, 100, 101 give 3, 4, 5), addr[7] test mode and addr[8] DLL reset. The new values show on the outputs in the cycle after the edge.
- R6: A register-set command to bank 01 loads the extended register. `dll_en` is the inverse of addr[0], and `drive_str` is {addr[6],addr[1]}, with 00 full, 01 weak and 11 matched.
- R7: A burst length code outside {001,010,011,111}, a latency code outside {011,100,101}, or burst length 111 together with addr[3]=1 raises `cfg_err` for one cycle and leaves the mode register outputs unchanged.
- R8: A drive strength code of 10 in an extended register write raises `cfg_err` and leaves the extended register unchanged. A register-set command with bank[1]=1 raises `cfg_err`, writes neither register and gives the no-op code.
- R9: A refresh taken while clock enable falls from high to low gives self-refresh entry (bit 9). The next low-to-high edge of clock enable gives self-refresh exit (bit 10).
- R10: Any other command taken while clock enable falls gives power-down entry (bit 13), and the next rise gives power-down exit (bit 14). The command itself is not executed, so a register set is not written. While clock enable stays low, and on a rise with no low-power state pending, `cmd` is zero.
- R11: Each valid flag rises with the first accepted write of its register and then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank bits |
| addr | input | ROW_W | Address and register op-code |
| cmd | output | 15 | Registered one-hot decoded command |
| cmd_bank | output | BA_W | Bank of the decoded command |
| cmd_row | output | ROW_W | Address sampled with the command |
| cmd_col | output | COL_W | Column of the decoded command |
| cmd_ap | output | 1 | Auto-precharge request with read or write |
| burst_len | output | COL_W+1 | Burst length in beats, 0 before the first write |
| burst_ilv | output | 1 | Interleaved burst ordering |
| cas_lat | output | 3 | Read latency in cycles |
| test_mode | output | 1 | Test mode bit |
| dll_reset | output | 1 | DLL reset request |
| mr_valid | output | 1 | Mode register has been written |
| dll_en | output | 1 | DLL enabled |
| drive_str | output | 2 | Output drive strength code |
| emr_valid | output | 1 | Extended register has been written |
| cfg_err | output | 1 | One-cycle pulse for a rejected register write |

## Verification
Every result of this block is due exactly one clock edge after the command is sampled. The decoded `cmd` bits and their bank, row, column and auto-precharge fields are registered at that edge. The mode outputs are decoded straight from registers loaded at that same edge. The `cfg_err` pulse is high for that one cycle only. The bench applies each command at a falling edge and samples at the next falling edge, so exactly one rising edge lies between stimulus and check. A rejected write is checked for its unchanged outputs in that same cycle, and its error pulse is checked as cleared one cycle later.

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode #(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             cke,
  input  logic [BA_W-1:0]  ba,
  input  logic [ROW_W-1:0] addr,
  output logic [14:0]      cmd,
  output logic [BA_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             cmd_ap,
  output logic [COL_W:0]   burst_len,
  output logic             burst_ilv,
  output logic [2:0]       cas_lat,
  output logic             test_mode,
  output logic             dll_reset,
  output logic             mr_valid,
  output logic             dll_en,
  output logic [1:0]       drive_str,
  output logic             emr_valid,
  output logic             cfg_err
);
  localparam int C_DESEL = 0, C_NOP = 1, C_ACT = 2, C_PRE = 3, C_PREA = 4;
  localparam int C_RD = 5, C_WR = 6, C_BST = 7, C_AREF = 8, C_SRE = 9;
  localparam int C_SRX = 10, C_MRS = 11, C_EMRS = 12, C_PDE = 13, C_PDX = 14;
  localparam logic [COL_W:0] ONE  = 1;
  localparam logic [COL_W:0] FULL = ONE << COL_W;

  logic       cke_q, in_sref, in_pd, dll_off;
  logic [8:0] mr;
  logic [1:0] ds;
  logic [14:0] nxt;

  wire [2:0] rcw    = {ras_n, cas_n, we_n};
  wire       run    = cke_q & cke;
  wire       fall   = cke_q & ~cke;
  wire       rise   = ~cke_q & cke;
  wire       is_ref = ~cs_n & (rcw == 3'b001);
  wire       is_set = run & ~cs_n & (rcw == 3'b000);
  wire       is_col = ~cs_n & rcw[2] & ~rcw[1];

  wire [2:0] bl_c = addr[2:0];
  wire [2:0] cl_c = addr[6:4];
  wire bl_ok   = (bl_c == 3'b001) | (bl_c == 3'b010) | (bl_c == 3'b011) | (bl_c == 3'b111);
  wire cl_ok   = (cl_c == 3'b011) | (cl_c == 3'b100) | (cl_c == 3'b101);
  wire mr_good = bl_ok & cl_ok & ~((bl_c == 3'b111) & addr[3]);
  wire emr_good = ~(addr[6] & ~addr[1]);
  wire mr_wr   = is_set & (ba == BA_W'(0));
  wire emr_wr  = is_set & (ba == BA_W'(1));
  wire bad_sel = is_set & (ba > BA_W'(1));

  always_comb begin
    nxt = '0;
    if (run) begin
      if (cs_n) nxt[C_DESEL] = 1'b1;
      else begin
        case (rcw)
          3'b111: nxt[C_NOP] = 1'b1;
          3'b011: nxt[C_ACT] = 1'b1;
          3'b010: nxt[addr[8] ? C_PREA : C_PRE] = 1'b1;
          3'b101: nxt[C_RD] = 1'b1;
          3'b100: nxt[C_WR] = 1'b1;
          3'b110: nxt[C_BST] = 1'b1;
          3'b001: nxt[C_AREF] = 1'b1;
          default: begin
            if (ba == BA_W'(0))      nxt[C_MRS]  = 1'b1;
            else if (ba == BA_W'(1)) nxt[C_EMRS] = 1'b1;
            else                     nxt[C_NOP]  = 1'b1;
          end
        endcase
      end
    end else if (fall) begin
      nxt[is_ref ? C_SRE : C_PDE] = 1'b1;
    end else if (rise) begin
      if (in_sref)    nxt[C_SRX] = 1'b1;
      else if (in_pd) nxt[C_PDX] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q     <= 1'b0;
      in_sref   <= 1'b0;
      in_pd     <= 1'b0;
      cmd       <= '0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      cmd_ap    <= 1'b0;
      mr        <= '0;
      mr_valid  <= 1'b0;
      dll_off   <= 1'b1;
      ds        <= '0;
      emr_valid <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      cke_q    <= cke;
      cmd      <= nxt;
      cmd_bank <= ba;
      cmd_row  <= addr;
      cmd_col  <= addr[COL_W-1:0];
      cmd_ap   <= run & is_col & addr[8];
      if (fall & is_ref)  in_sref <= 1'b1;
      else if (rise)      in_sref <= 1'b0;
      if (fall & ~is_ref) in_pd <= 1'b1;
      else if (rise)      in_pd <= 1'b0;
      if (mr_wr & mr_good) begin
        mr       <= addr[8:0];
        mr_valid <= 1'b1;
      end
      if (emr_wr & emr_good) begin
        dll_off   <= addr[0];
        ds        <= {addr[6], addr[1]};
        emr_valid <= 1'b1;
      end
      cfg_err <= (mr_wr & ~mr_good) | (emr_wr & ~emr_good) | bad_sel;
    end
  end

  assign burst_len = !mr_valid ? '0 : (&mr[2:0]) ? FULL : (ONE << mr[2:0]);
  assign burst_ilv = mr[3];
  assign cas_lat   = mr[6:4];
  assign test_mode = mr[7];
  assign dll_reset = mr[8];
  assign dll_en    = emr_valid & ~dll_off;
  assign drive_str = ds;
endmodule

// File: rtl/sdram_cmd_decode_chk.sv
module sdram_cmd_decode_chk #(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  parameter int BA_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             cke,
  input logic             cke_q,
  input logic [BA_W-1:0]  ba,
  input logic [ROW_W-1:0] addr,
  input logic [14:0]      cmd,
  input logic [COL_W:0]   burst_len,
  input logic             burst_ilv,
  input logic [1:0]       drive_str,
  input logic             cfg_err,
  input logic             mr_valid
);
  wire set_cmd = cke_q && cke && !cs_n && !ras_n && !cas_n && !we_n;

  // R2
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cmd));

  // R3
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && cke && cs_n) |=> (cmd == 15'd1));

  // R7
  bl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd && ba == BA_W'(0) && addr[2:0] == 3'b000) |=> (cfg_err && $stable(burst_len)));

  // R7
  page_ilv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd && ba == BA_W'(0) && addr[3:0] == 4'b1111) |=> (cfg_err && $stable(burst_ilv)));

  // R8
  ds_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd && ba == BA_W'(1) && addr[6] && !addr[1]) |=> (cfg_err && $stable(drive_str)));

  // R9
  sref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && !cke && !cs_n && !ras_n && !cas_n && we_n) |=> cmd[9]);

  // R11
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mr_valid |=> mr_valid);
endmodule

bind sdram_cmd_decode sdram_cmd_decode_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .cke(cke), .cke_q(cke_q), .ba(ba), .addr(addr), .cmd(cmd), .burst_len(burst_len),
  .burst_ilv(burst_ilv), .drive_str(drive_str), .cfg_err(cfg_err), .mr_valid(mr_valid));

// File: tb/sdram_cmd_decode_tb.sv
`timescale 1ns/1ps
module sdram_cmd_decode_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic [14:0] cmd;
  logic [1:0] cmd_bank;
  logic [11:0] cmd_row;
  logic [7:0] cmd_col;
  logic cmd_ap, burst_ilv, test_mode, dll_reset, mr_valid, dll_en, emr_valid, cfg_err;
  logic [8:0] burst_len;
  logic [2:0] cas_lat;
  logic [1:0] drive_str;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sdram_cmd_decode dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .addr(addr), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_ap(cmd_ap), .burst_len(burst_len), .burst_ilv(burst_ilv),
    .cas_lat(cas_lat), .test_mode(test_mode), .dll_reset(dll_reset), .mr_valid(mr_valid),
    .dll_en(dll_en), .drive_str(drive_str), .emr_valid(emr_valid), .cfg_err(cfg_err));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] bit_of(input int n);
    return 15'(1) << n;
  endfunction

  // applies one command at the current falling edge, returns one falling edge later
  task automatic issue(input logic c, input logic [2:0] s, input logic k,
                       input logic [1:0] b, input logic [11:0] a);
    cs_n = c; {ras_n, cas_n, we_n} = s; cke = k; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic nop();
    issue(1'b0, 3'b111, 1'b1, 2'b00, 12'h000);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 cmd in reset", cmd, 0);
    rst_n = 1'b1;
    nop();
    check("R1 cmd first cycle", cmd, 0);
    check("R1 mr_valid", mr_valid, 0);
    check("R1 emr_valid", emr_valid, 0);
    check("R1 burst_len", burst_len, 0);
    check("R1 cas_lat", cas_lat, 0);
    check("R1 dll_en", dll_en, 0);
    check("R1 drive_str", drive_str, 0);
    check("R1 cfg_err", cfg_err, 0);
    nop();
    check("R2 nop", cmd, bit_of(1));
  endtask

  task automatic t_decode();
    issue(1'b0, 3'b011, 1'b1, 2'b10, 12'hABC);
    check("R2 activate", cmd, bit_of(2));
    check("R4 activate bank", cmd_bank, 2'b10);
    check("R4 activate row", cmd_row, 12'hABC);
    check("R4 activate ap", cmd_ap, 0);
    issue(1'b0, 3'b010, 1'b1, 2'b01, 12'h000);
    check("R2 precharge one", cmd, bit_of(3));
    issue(1'b0, 3'b010, 1'b1, 2'b00, 12'h100);
    check("R2 precharge all", cmd, bit_of(4));
    check("R4 precharge ap", cmd_ap, 0);
    issue(1'b0, 3'b101, 1'b1, 2'b11, 12'h15A);
    check("R2 read", cmd, bit_of(5));
    check("R4 read col", cmd_col, 8'h5A);
    check("R4 read ap", cmd_ap, 1);
    check("R4 read bank", cmd_bank, 2'b11);
    issue(1'b0, 3'b100, 1'b1, 2'b01, 12'h0C3);
    check("R2 write", cmd, bit_of(6));
    check("R4 write col", cmd_col, 8'hC3);
    check("R4 write ap", cmd_ap, 0);
    issue(1'b0, 3'b110, 1'b1, 2'b00, 12'h000);
    check("R2 burst stop", cmd, bit_of(7));
    issue(1'b1, 3'b011, 1'b1, 2'b00, 12'h000);
    check("R3 deselect over activate", cmd, bit_of(0));
    issue(1'b1, 3'b000, 1'b1, 2'b00, 12'h043);
    check("R3 deselect over register set", cmd, bit_of(0));
    check("R3 no register write", mr_valid, 0);
  endtask

  task automatic t_mode();
    issue(1'b0, 3'b000, 1'b1, 2'b00, 12'h043);
    check("R2 mode set", cmd, bit_of(11));
    check("R5 bl 8", burst_len, 8);
    check("R5 seq", burst_ilv, 0);
    check("R5 cl 4", cas_lat, 4);
    check("R11 mr_valid", mr_valid, 1);
    check("R7 no err on good", cfg_err, 0);
    issue(1'b0, 3'b000, 1'b1, 2'b00, 12'h15A);
    check("R5 bl 4", burst_len, 4);
    check("R5 interleave", burst_ilv, 1);
    check("R5 cl 5", cas_lat, 5);
    check("R5 dll reset", dll_reset, 1);
    issue(1'b0, 3'b000, 1'b1, 2'b00, 12'h0B1);
    check("R5 bl 2", burst_len, 2);
    check("R5 cl 3", cas_lat, 3);
    check("R5 test mode", test_mode, 1);
    check("R5 dll reset clear", dll_reset, 0);
    issue(1'b0, 3'b000, 1'b1, 2'b00, 12'h037);
    check("R5 full page", burst_len, 256);
    check("R5 test mode clear", test_mode, 0);
  endtask

  task automatic t_mode_bad();
    issue(1'b0, 3'b000, 1'b1, 2'b00, 12'h030);
    check("R7 bl rsvd err", cfg_err, 1);
    check("R7 bl kept", burst_len, 256);
    nop();
    check("R7 err one cycle", cfg_err, 0);
    issue(1'b0, 3'b000, 1'b1, 2'b00, 12'h062);
    check("R7 cl rsvd err", cfg_err, 1);
    check("R7 cl kept", cas_lat, 3);
    check("R7 bl kept after cl", burst_len, 256);
    issue(1'b0, 3'b000, 1'b1, 2'b00, 12'h03F);
    check("R7 page interleave err", cfg_err, 1);
    check("R7 ordering kept", burst_ilv, 0);
    check("R7 page kept", burst_len, 256);
    nop();
  endtask

  task automatic t_ext();
    check("R11 emr_valid before", emr_valid, 0);
    issue(1'b0, 3'b000, 1'b1, 2'b01, 12'h002);
    check("R2 ext set", cmd, bit_of(12));
    check("R6 dll on", dll_en, 1);
    check("R6 weak", drive_str, 2'b01);
    check("R11 emr_valid", emr_valid, 1);
    check("R6 mode untouched", burst_len, 256);
    issue(1'b0, 3'b000, 1'b1, 2'b01, 12'h043);
    check("R6 dll off", dll_en, 0);
    check("R6 matched", drive_str, 2'b11);
    issue(1'b0, 3'b000, 1'b1, 2'b01, 12'h040);
    check("R8 ds rsvd err", cfg_err, 1);
    check("R8 ds kept", drive_str, 2'b11);
    check("R8 dll kept", dll_en, 0);
    issue(1'b0, 3'b000, 1'b1, 2'b10, 12'h043);
    check("R8 bank1x is nop", cmd, bit_of(1));
    check("R8 bank1x err", cfg_err, 1);
    check("R8 bank1x mode kept", burst_len, 256);
    check("R8 bank1x ext kept", drive_str, 2'b11);
    nop();
  endtask

  task automatic t_refresh();
    issue(1'b0, 3'b001, 1'b1, 2'b00, 12'h000);
    check("R2 auto refresh", cmd, bit_of(8));
    issue(1'b0, 3'b001, 1'b0, 2'b00, 12'h000);
    check("R9 self refresh entry", cmd, bit_of(9));
    issue(1'b0, 3'b111, 1'b0, 2'b00, 12'h000);
    check("R10 held low zero", cmd, 0);
    issue(1'b0, 3'b001, 1'b0, 2'b00, 12'h000);
    check("R10 held low refresh zero", cmd, 0);
    issue(1'b0, 3'b111, 1'b1, 2'b00, 12'h000);
    check("R9 self refresh exit", cmd, bit_of(10));
    nop();
    check("R2 nop after exit", cmd, bit_of(1));
  endtask

  task automatic t_powerdown();
    issue(1'b0, 3'b000, 1'b0, 2'b00, 12'h043);
    check("R10 power-down entry", cmd, bit_of(13));
    check("R10 set not written", burst_len, 256);
    issue(1'b0, 3'b000, 1'b0, 2'b00, 12'h043);
    check("R10 low zero", cmd, 0);
    check("R10 set not written low", burst_len, 256);
    issue(1'b1, 3'b111, 1'b1, 2'b00, 12'h000);
    check("R10 power-down exit", cmd, bit_of(14));
    issue(1'b1, 3'b111, 1'b1, 2'b00, 12'h000);
    check("R3 deselect after exit", cmd, bit_of(0));
    check("R11 mr_valid stays", mr_valid, 1);
    check("R11 emr_valid stays", emr_valid, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_decode();
    t_mode();
    t_mode_bad();
    t_ext();
    t_refresh();
    t_powerdown();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule